// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Result Port

This block is the digital control for an 8-bit successive-approximation converter. It also drives the three-wire port that hands the result to a host. The block sleeps until a falling edge on the convert-start input. It then runs a fixed, internally counted acquisition window and a binary search. During the search it presents trial codes to an external capacitive DAC and reads back a one-bit comparator decision. The analog parts (sampling switch, DAC, comparator) sit outside. The block sees them only through a track control, a trial-code bus and the comparator bit.

The serial data line carries two kinds of information. While a conversion is in flight it is driven low, so the host can use it as a busy flag. When the search ends, the most significant result bit appears on the line with no clock edge. The host then pulls the remaining bits out with falling edges of its serial clock. After the last bit the line is released, and the block drops back into a powered-down idle state. The convert-start and serial-clock inputs are asynchronous. Each passes through a two-flop synchronizer before edge detection.

The acquisition length is a parameter. It must be sized so that acquisition plus the 2×W search cycles fits within 7.5 µs at the chosen clock rate.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, and in idle, the block asserts `pwr_dn_o`, holds `track_o` low, drives `dac_code_o` to zero and keeps `sdo_oe_o` low, so that `sdo_o` is high impedance.
- R2: A high-to-low transition on `conv_start_n_i` in idle deasserts `pwr_dn_o` and raises `track_o` on the third rising clock edge after the input changes, because of two synchronizer stages plus one edge-detect stage.
- R3: `track_o` stays high for exactly `ACQ_CYC` clock cycles, then falls as the search begins.
- R4: The search tests bits from W-1 down to 0, two cycles per bit. In the first cycle the bit under test is set to 1 on `dac_code_o` so the DAC can settle. In the second cycle the bit is kept if `cmp_i` is 1 (input at or above the DAC level) and cleared otherwise, and the next lower bit is set to 1. The first trial code is 0x80.
- R5: For an ideal comparator, the result equals the largest code whose DAC level is at or below the input. For 8 bits that is the input code itself.
- R6: From the start of acquisition until the result is ready, `sdo_oe_o` is high and `sdo_o` is 0.
- R7: Exactly 2×W clock cycles after `track_o` falls, `sdo_o` shows the result MSB without any serial clock edge.
- R8: Each synchronized falling edge of `sclk_i` in readout moves the next lower result bit onto `sdo_o`, MSB first. Rising edges leave it unchanged.
- R9: The W-th falling edge of `sclk_i` in readout lowers `sdo_oe_o` and returns the block to idle with `pwr_dn_o` asserted.
- R10: A convert-start falling edge during acquisition or search is ignored. Timing and result are unchanged.
- R11: A convert-start falling edge during readout abandons the readout and starts a new acquisition, with the same timing as R2.
- R12: Falling edges of `sclk_i` outside readout have no effect. In idle, `pwr_dn_o` stays high and `sdo_oe_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_start_n_i | input | 1 | Asynchronous convert-start; a falling edge begins a conversion |
| sclk_i | input | 1 | Asynchronous serial clock from the host |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above the DAC level |
| dac_code_o | output | W | Trial code for the capacitive DAC |
| track_o | output | 1 | High while the sampling switch tracks the input |
| pwr_dn_o | output | 1 | Power-down indication to the analog section |
| sdo_o | output | 1 | Serial data line, high impedance when released |
| sdo_oe_o | output | 1 | Output enable of the serial data line |

## Verification
The bench builds the block at its native 8-bit width with `ACQ_CYC` cut to 6. This keeps each conversion and readout under a hundred cycles, so all 256 input codes can be converted and shifted out against an ideal comparator model. It also keeps the acquisition window short enough to aim convert-start glitches at both the acquisition phase and the search phase. Readouts abandoned partway through are mixed into the sweep, and serial clock activity in idle is exercised before the first conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_READ = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_edge_sync.sv
// Two-flop synchronizer with a third stage for falling-edge detection.
module sar_edge_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {3{RST_VAL}};
    else        pipe_q <= {pipe_q[1:0], async_i};
  end

  assign fall_o = pipe_q[2] & ~pipe_q[1];
endmodule

// File: rtl/sar_search.sv
// Binary-search datapath: one settle cycle and one decide cycle per bit.
module sar_search #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         en_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         last_o,
  output logic [W-1:0] result_o
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  logic [W-1:0]     code_q, code_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             decide_q, decide_d;

  assign code_o   = code_q;
  assign last_o   = en_i && decide_q && (idx_q == '0);
  assign result_o = {code_q[W-1:1], cmp_i};

  always_comb begin
    code_d   = code_q;
    idx_d    = idx_q;
    decide_d = decide_q;
    if (load_i) begin
      code_d   = '0;
      code_d[W-1] = 1'b1;
      idx_d    = TOP_IDX;
      decide_d = 1'b0;
    end else if (en_i) begin
      if (!decide_q) begin
        decide_d = 1'b1;
      end else begin
        code_d[idx_q] = cmp_i;
        if (idx_q != '0) begin
          code_d[idx_q - 1'b1] = 1'b1;
          idx_d = idx_q - 1'b1;
        end
        decide_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      idx_q    <= '0;
      decide_q <= 1'b0;
    end else begin
      code_q   <= code_d;
      idx_q    <= idx_d;
      decide_q <= decide_d;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Conversion sequencer and serial result port.
// ACQ_CYC plus 2*W search cycles must fit in 7.5 us at the clock used.
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int W       = 8,
  parameter int ACQ_CYC = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start_n_i,
  input  logic         sclk_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_code_o,
  output logic         track_o,
  output logic         pwr_dn_o,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  localparam int CNT_MAX = (ACQ_CYC > W) ? ACQ_CYC : W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(W - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic start_fall, sclk_fall;

  sar_edge_sync #(.RST_VAL(1'b1)) u_start_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(conv_start_n_i), .fall_o(start_fall)
  );
  sar_edge_sync #(.RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(sclk_i), .fall_o(sclk_fall)
  );

  sar_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     shreg_q, shreg_d;
  logic             srch_load, srch_en, srch_last;
  logic [W-1:0]     srch_code, srch_result;

  sar_search #(.W(W)) u_search (
    .clk(clk), .rst_n(rst_int_n), .load_i(srch_load), .en_i(srch_en),
    .cmp_i(cmp_i), .code_o(srch_code), .last_o(srch_last), .result_o(srch_result)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shreg_d   = shreg_q;
    srch_load = 1'b0;
    srch_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_fall) begin
          state_d = ST_ACQ;
          cnt_d   = '0;
        end
      end
      ST_ACQ: begin
        if (cnt_q == ACQ_LAST) begin
          state_d   = ST_CONV;
          cnt_d     = '0;
          srch_load = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        srch_en = 1'b1;
        if (srch_last) begin
          state_d = ST_READ;
          shreg_d = srch_result;
          cnt_d   = '0;
        end
      end
      ST_READ: begin
        if (start_fall) begin
          state_d = ST_ACQ;
          cnt_d   = '0;
        end else if (sclk_fall) begin
          if (cnt_q == BIT_LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            shreg_d = {shreg_q[W-2:0], 1'b0};
            cnt_d   = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
    end
  end

  logic sdo_d;
  assign sdo_d      = (state_q == ST_READ) & shreg_q[W-1];
  assign sdo_oe_o   = (state_q != ST_IDLE);
  assign sdo_o      = sdo_oe_o ? sdo_d : 1'bz;
  assign track_o    = (state_q == ST_ACQ);
  assign pwr_dn_o   = (state_q == ST_IDLE);
  assign dac_code_o = (state_q == ST_IDLE) ? '0 : srch_code;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] dac_code,
  input logic         track,
  input logic         pwr_dn,
  input logic         sdo_oe,
  input logic         sdo_d,
  input logic         in_conv,
  input logic         in_read,
  input logic         start_fall,
  input logic         sclk_fall,
  input logic [W-1:0] shreg
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!sdo_oe && dac_code == '0));

  a_r2_wake_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn) |-> track);

  a_r4_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track) |-> (dac_code == MSB_ONLY && !pwr_dn));

  a_r6_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (track || in_conv) |-> (sdo_oe && !sdo_d));

  a_r8_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && !sclk_fall && !start_fall) |=> $stable(shreg));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && start_fall) |=> !track);

  a_r11_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && start_fall) |=> track);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) u_chk (
  .clk(clk),
  .rst_n(rst_int_n),
  .dac_code(dac_code_o),
  .track(track_o),
  .pwr_dn(pwr_dn_o),
  .sdo_oe(sdo_oe_o),
  .sdo_d(sdo_d),
  .in_conv(state_q == sar_pkg::ST_CONV),
  .in_read(state_q == sar_pkg::ST_READ),
  .start_fall(start_fall),
  .sclk_fall(sclk_fall),
  .shreg(shreg_q)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int W   = 8;
  localparam int ACQ = 6;

  logic         clk = 1'b0;
  logic         rst_n, start_n, sclk;
  logic [W-1:0] vin;
  logic [W-1:0] dac_code;
  logic         track, pwr_dn, sdo_oe, cmp;
  wire          sdo;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  assign cmp = (vin >= dac_code);

  sar_adc_ctrl #(.W(W), .ACQ_CYC(ACQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start_n_i(start_n), .sclk_i(sclk),
    .cmp_i(cmp), .dac_code_o(dac_code), .track_o(track), .pwr_dn_o(pwr_dn),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_pulse();
    @(negedge clk); start_n = 1'b1;
    repeat (3) @(negedge clk);
    start_n = 1'b0;
  endtask

  // glitch: 0 none, 1 during acquisition, 2 during search
  task automatic convert(input logic [W-1:0] v, input int glitch, input bit from_read);
    vin = v;
    start_pulse();
    fork
      begin
        tick(2);
        if (from_read) chk(!track && !pwr_dn, "R11 still reading", {7'b0, track}, 0);
        else chk(pwr_dn && !track, "R2 not yet awake", {7'b0, pwr_dn}, 1);
        tick(1);
        chk(track && !pwr_dn, from_read ? "R11 restart tracks" : "R2 wake tracks",
            {6'b0, pwr_dn, track}, 8'h01);
        chk(sdo_oe && sdo === 1'b0, "R6 busy low in acquisition", {7'b0, sdo}, 0);
        tick(ACQ - 1);
        chk(track, "R3 acquisition still on", {7'b0, track}, 1);
        tick(1);
        chk(!track, "R3 acquisition ended", {7'b0, track}, 0);
        chk(dac_code == 8'h80, "R4 first trial", dac_code, 8'h80);
        tick(2);
        chk(dac_code == {v[7], 1'b1, 6'b0}, "R4 second trial",
            dac_code, {v[7], 1'b1, 6'b0});
        tick(2 * W - 3);
        chk(sdo_oe && sdo === 1'b0, "R6 busy low in search", {7'b0, sdo}, 0);
        tick(1);
        chk(sdo_oe && sdo === v[7], "R7 MSB without clock", {7'b0, sdo}, {7'b0, v[7]});
      end
      begin
        if (glitch == 1) begin
          @(negedge clk); start_n = 1'b1;
          repeat (2) @(negedge clk); start_n = 1'b0;
        end else if (glitch == 2) begin
          repeat (8) @(negedge clk); start_n = 1'b1;
          repeat (3) @(negedge clk); start_n = 1'b0;
        end
      end
    join
  endtask

  task automatic readout(input logic [W-1:0] v, input int nbits);
    logic [W-1:0] got;
    got = '0;
    got[W-1] = sdo;
    for (int i = 1; i <= nbits && i < W; i++) begin
      @(negedge clk); sclk = 1'b1;
      tick(3);
      chk(sdo === v[W-i], "R8 rise keeps bit", {7'b0, sdo}, {7'b0, v[W-i]});
      @(negedge clk); sclk = 1'b0;
      tick(4);
      chk(sdo === v[W-1-i], "R8 fall shifts bit", {7'b0, sdo}, {7'b0, v[W-1-i]});
      got[W-1-i] = sdo;
    end
    if (nbits >= W) begin
      chk(got == v, "R5 result equals input code", got, v);
      @(negedge clk); sclk = 1'b1;
      tick(3);
      @(negedge clk); sclk = 1'b0;
      tick(4);
      chk(!sdo_oe && pwr_dn, "R9 released after last bit",
          {6'b0, sdo_oe, pwr_dn}, 8'h01);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit aborted;
    rst_n = 1'b0; start_n = 1'b1; sclk = 1'b0; vin = '0;
    tick(3);
    chk(pwr_dn && !sdo_oe && !track, "R1 reset idle", {5'b0, pwr_dn, sdo_oe, track}, 8'h04);
    @(negedge clk); rst_n = 1'b1;
    tick(5);
    chk(pwr_dn && !sdo_oe && dac_code == '0, "R1 idle after release", dac_code, 0);

    // R12: serial clock activity while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sclk = 1'b1;
      tick(3);
      @(negedge clk); sclk = 1'b0;
      tick(4);
      chk(pwr_dn && !sdo_oe, "R12 sclk ignored in idle", {6'b0, pwr_dn, sdo_oe}, 8'h02);
    end

    aborted = 1'b0;
    for (int v = 0; v < 256; v++) begin
      int g;
      g = (v % 16 == 5) ? 1 : ((v % 16 == 9) ? 2 : 0);
      if (g != 0) $display("R10 glitch mode %0d at code %0h", g, v);
      convert(W'(v), g, aborted);
      if (v % 37 == 3) begin
        readout(W'(v), 3);
        aborted = 1'b1;
      end else begin
        readout(W'(v), W);
        aborted = 1'b0;
      end
    end
    finish_run();
  end
endmodule